// File: doc/BRIEF.md
# Host Register Port for a Color Palette with 6-bit and 8-bit Data Modes

This block is the processor-facing access port of a video color palette. A host reads and writes palette locations through an active-low read strobe, an active-low write strobe, a 4-bit location select and an 8-bit data bus. The bus is split into an input half and an output half, and an output enable tells the pad driver when to drive. Both strobes and the resolution input are asynchronous to the system clock. Each one passes through a chain of synchronizer flops, and the block acts on the strobe edges it detects in the synchronized signals.

Location 0 is the palette holding register and locations 1 to 15 are color entries. Every location keeps a full 8-bit value in both modes. The resolution input sets how that value is presented. In 6-bit mode a readback clears the two top bits, while the value sent toward the DAC is shifted up by two places with zeros in the two lowest bits. The read path and the DAC path therefore transform the same stored byte in different ways. The DAC side chooses a location with its own select and receives the formatted byte from a register.

Top module: `hpal_host_port`

## Requirements
- R1: After reset every location holds zero, the mode is 8-bit, the output enable is low and the DAC output is zero.
- R2: On the rising edge of the write strobe, the value on the input bus is stored into the location named by the select lines. All 8 bits are kept in both modes.
- R3: A falling edge of the read strobe loads the read register from the location named by the select lines. The 16 locations are independent of each other.
- R4: The output enable is high only while the synchronized read strobe is low and the synchronized write strobe is high. Once the read strobe has been high for the synchronizer depth, the enable is low.
- R5: In 8-bit mode (resolution input high) a readback returns the stored byte unchanged, with bit 7 as the MSB and bit 0 as the LSB.
- R6: In 6-bit mode (resolution input low) a readback returns the stored byte with bits 7 and 6 forced to zero. On return to 8-bit mode the full stored byte reads back again.
- R7: In 8-bit mode the DAC output equals the stored byte of the location on the DAC select. It is registered, so it follows the DAC select one clock later.
- R8: In 6-bit mode the DAC output is {stored[5:0], 2'b00}: stored bit 5 appears at bit 7, stored bit 0 appears at bit 2, and bits 1 and 0 are zero.
- R9: If the read strobe falls while the write strobe is low, the read register loads zero and the output enable stays low until the write strobe rises. The write still completes.
- R10: Each strobe edge is acted on after two synchronizer flops. A write whose strobe rises between clock edges changes the DAC output of that location on the fourth rising clock edge, not before. Each detected edge is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| rsel | input | 4 | Location select for host access |
| res8_i | input | 1 | Resolution select: high for 8-bit, low for 6-bit |
| data_i | input | 8 | Host write data |
| data_o | output | 8 | Host read data |
| data_oe | output | 1 | Enable for the pad driver of the data bus |
| dac_sel | input | 4 | Location select for the DAC side |
| dac_o | output | 8 | Formatted byte toward the DAC |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 6-bit narrow mode, a 4-bit select and two synchronizer stages. With those values all 16 locations can be swept in both modes. The expected bytes are computed arithmetically from a per-location pattern that uses every bit position, which exercises the read mask, the DAC shift and retention across a mode change at every address. The small synchronizer depth also keeps the exact write-to-output latency within reach, as well as the case where both strobes are asserted together.

// File: rtl/hpal_pkg.sv
package hpal_pkg;
   typedef enum logic {
      RES_NARROW = 1'b0,
      RES_FULL   = 1'b1
   } res_e;

   typedef enum int {
      FMT_READ = 0,
      FMT_DAC  = 1
   } fmt_kind_e;
endpackage

// File: rtl/hpal_sync.sv
module hpal_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   localparam int CHAIN = STAGES + 1;

   logic [CHAIN-1:0] chain_q;

   if (STAGES < 2) begin : g_bad_depth
      $error("hpal_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= RESET_VAL;
      else        chain_q[0] <= async_i;
   end

   for (genvar s = 1; s < CHAIN; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= RESET_VAL;
         else        chain_q[s] <= chain_q[s-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
   assign fall_o  = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/hpal_store.sv
module hpal_store #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [DATA_W-1:0] rd_val,
   input  logic [SEL_W-1:0]  dac_sel,
   output logic [DATA_W-1:0] dac_val
);
   localparam int DEPTH = 1 << SEL_W;

   logic [DATA_W-1:0] loc_q [DEPTH];

   if (DEPTH > 256) begin : g_bad_depth
      $error("hpal_store: select width too large");
   end

   for (genvar k = 0; k < DEPTH; k++) begin : g_loc
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            loc_q[k] <= '0;
         else if (wr_en && (wr_sel == SEL_W'(k)))
            loc_q[k] <= wr_data;
      end
   end

   assign rd_val  = loc_q[rd_sel];
   assign dac_val = loc_q[dac_sel];
endmodule

// File: rtl/hpal_fmt.sv
module hpal_fmt
   import hpal_pkg::*;
#(
   parameter int        DATA_W   = 8,
   parameter int        NARROW_W = 6,
   parameter fmt_kind_e KIND     = FMT_READ
) (
   input  logic [DATA_W-1:0] val_i,
   input  res_e              res_i,
   output logic [DATA_W-1:0] val_o
);
   localparam int PAD_W = DATA_W - NARROW_W;

   if (NARROW_W >= DATA_W || NARROW_W < 1) begin : g_bad_width
      $error("hpal_fmt: NARROW_W must lie between 1 and DATA_W-1");
   end

   logic [DATA_W-1:0] narrow;

   if (KIND == FMT_READ) begin : g_read
      // readback: clear the bits above the narrow field
      assign narrow = {{PAD_W{1'b0}}, val_i[NARROW_W-1:0]};
   end else begin : g_dac
      // DAC side: left-justify, zero fill below
      assign narrow = {val_i[NARROW_W-1:0], {PAD_W{1'b0}}};
   end

   assign val_o = (res_i == RES_FULL) ? val_i : narrow;
endmodule

// File: rtl/hpal_host_port.sv
module hpal_host_port
   import hpal_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int NARROW_W    = 6,
   parameter int SEL_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [SEL_W-1:0]  rsel,
   input  logic              res8_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o,
   output logic              data_oe,
   input  logic [SEL_W-1:0]  dac_sel,
   output logic [DATA_W-1:0] dac_o
);
   if (DATA_W < 2) begin : g_bad_data
      $error("hpal_host_port: DATA_W must be at least 2");
   end

   logic rd_lvl, rd_rise, rd_fall;
   logic wr_lvl, wr_rise, wr_fall;
   logic res_lvl, res_rise, res_fall;
   res_e res8_q;

   hpal_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .async_i(rd_n),
      .level_o(rd_lvl), .rise_o(rd_rise), .fall_o(rd_fall));

   hpal_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_wr_sync (
      .clk(clk), .rst_n(rst_n), .async_i(wr_n),
      .level_o(wr_lvl), .rise_o(wr_rise), .fall_o(wr_fall));

   hpal_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_res_sync (
      .clk(clk), .rst_n(rst_n), .async_i(res8_i),
      .level_o(res_lvl), .rise_o(res_rise), .fall_o(res_fall));

   assign res8_q = res_e'(res_lvl);

   logic [DATA_W-1:0] store_rd, store_dac;
   logic [DATA_W-1:0] fmt_rd, fmt_dac;
   logic [DATA_W-1:0] rd_data;

   hpal_store #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_rise), .wr_sel(rsel), .wr_data(data_i),
      .rd_sel(rsel), .rd_val(store_rd),
      .dac_sel(dac_sel), .dac_val(store_dac));

   hpal_fmt #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .KIND(FMT_READ)) u_fmt_rd (
      .val_i(store_rd), .res_i(res8_q), .val_o(fmt_rd));

   hpal_fmt #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .KIND(FMT_DAC)) u_fmt_dac (
      .val_i(store_dac), .res_i(res8_q), .val_o(fmt_dac));

   // read register: a write in progress wins and forces zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (rd_fall)
         rd_data <= wr_lvl ? fmt_rd : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dac_o <= '0;
      else        dac_o <= fmt_dac;
   end

   assign data_oe = ~rd_lvl & wr_lvl;
   assign data_o  = data_oe ? rd_data : '0;
endmodule

// File: rtl/hpal_host_port_chk.sv
module hpal_host_port_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_n,
   input logic              rd_fall,
   input logic              wr_rise,
   input logic              wr_lvl,
   input logic              res_lvl,
   input logic              data_oe,
   input logic [DATA_W-1:0] rd_data,
   input logic [DATA_W-1:0] dac_o
);
   a_r4_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n && $past(rd_n) && $past(rd_n, 2)) |-> !data_oe);

   a_r8_dac_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(res_lvl) |-> (dac_o[1:0] == 2'b00));

   a_r9_collide_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fall && !wr_lvl) |=> (rd_data == '0));

   a_r9_collide_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_lvl |-> !data_oe);

   a_r10_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fall |=> !rd_fall);

   a_r10_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rise |=> !wr_rise);
endmodule

bind hpal_host_port hpal_host_port_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rd_fall(rd_fall),
   .wr_rise(wr_rise), .wr_lvl(wr_lvl), .res_lvl(res_lvl),
   .data_oe(data_oe), .rd_data(rd_data), .dac_o(dac_o));

// File: tb/hpal_host_port_bench.sv
module hpal_host_port_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_n = 1'b1;
   logic       wr_n = 1'b1;
   logic [3:0] rsel = '0;
   logic       res8_i = 1'b1;
   logic [7:0] data_i = '0;
   logic [7:0] data_o;
   logic       data_oe;
   logic [3:0] dac_sel = '0;
   logic [7:0] dac_o;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   hpal_host_port u_hpal_host_port (
      .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .rsel(rsel),
      .res8_i(res8_i), .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
      .dac_sel(dac_sel), .dac_o(dac_o));

   function automatic logic [7:0] pat(input int k);
      return 8'((k * 53 + 29) % 256);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic negs(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_write(input logic [3:0] sel, input logic [7:0] val);
      rsel = sel; data_i = val; wr_n = 1'b0;
      negs(3);
      wr_n = 1'b1;
      negs(5);
   endtask

   task automatic do_read(input string req, input logic [3:0] sel, input logic [7:0] exp);
      rsel = sel; rd_n = 1'b0;
      negs(5);
      check({req, " oe"}, {7'd0, data_oe}, 8'd1);
      check(req, data_o, exp);
      rd_n = 1'b1;
      negs(4);
      check("R4 release", {7'd0, data_oe}, 8'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      negs(3);
      check("R1 oe at reset", {7'd0, data_oe}, 8'd0);
      check("R1 dac at reset", dac_o, 8'd0);
      rst_n = 1'b1;
      negs(4);
      check("R4 idle oe", {7'd0, data_oe}, 8'd0);
      for (int k = 0; k < 16; k++) do_read("R1 cleared", 4'(k), 8'd0);
      for (int k = 0; k < 16; k++) begin
         dac_sel = 4'(k); negs(1);
         check("R1 dac cleared", dac_o, 8'd0);
      end

      // 8-bit mode: write and read back every location
      for (int k = 0; k < 16; k++) do_write(4'(k), pat(k));
      for (int k = 0; k < 16; k++) do_read("R2 R3 R5 full read", 4'(k), pat(k));
      for (int k = 0; k < 16; k++) begin
         dac_sel = 4'(k); negs(1);
         check("R7 dac full", dac_o, pat(k));
      end

      // 6-bit mode
      res8_i = 1'b0; negs(4);
      for (int k = 0; k < 16; k++) do_read("R6 narrow read", 4'(k), pat(k) & 8'h3F);
      for (int k = 0; k < 16; k++) begin
         dac_sel = 4'(k); negs(1);
         check("R8 dac narrow", dac_o, {pat(k)[5:0], 2'b00});
      end
      do_write(4'd9, 8'hC3);
      res8_i = 1'b1; negs(4);
      do_read("R6 retained", 4'd9, 8'hC3);
      do_read("R6 retained other", 4'd5, pat(5));

      // write-to-DAC latency
      dac_sel = 4'd3; rsel = 4'd3; data_i = 8'h5A; wr_n = 1'b0;
      negs(4);
      check("R10 before", dac_o, pat(3));
      wr_n = 1'b1;
      negs(3);
      check("R10 three edges", dac_o, pat(3));
      negs(1);
      check("R10 four edges", dac_o, 8'h5A);
      negs(4);

      // collision
      rsel = 4'd7; data_i = 8'hA5; rd_n = 1'b0; wr_n = 1'b0;
      negs(5);
      check("R9 no drive during write", {7'd0, data_oe}, 8'd0);
      wr_n = 1'b1;
      negs(5);
      check("R9 oe after write", {7'd0, data_oe}, 8'd1);
      check("R9 zero data", data_o, 8'd0);
      rd_n = 1'b1;
      negs(4);
      do_read("R9 write completed", 4'd7, 8'hA5);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule